// File: doc/BRIEF.md
# Shared-Memory Phase Arbiter

This block serialises access to a shared memory among several requesters, one per core or partition, each of which repeats a fixed three-step life: it loads its working set from shared memory, works on it privately, then stores its results back. Only the load and store steps touch shared memory. The arbiter therefore gives out a single memory token, one requester at a time, for those two steps. The private compute step needs no token, so any number of requesters may compute at once, alongside whichever requester holds the token.

Each requester has a start line, a compute-done pulse, a transfer-done pulse, a grant line and a three-bit phase code. The arbiter keeps the phase of every requester. When the token is free, or is being released in the current cycle, it picks the next holder by round-robin among all requesters that are waiting to load or waiting to store. The search begins just after the most recent holder. All pins are plain level or pulse controls. No data passes through the block, so it has no valid/ready stream interface.

Top module: `sparb_top`

## Requirements
- R1: After reset, every requester's phase is idle (code 0) and every grant is low.
- R2: A requester in idle with its start line high moves to wait-load (code 1) at the next clock edge.
- R3: At most one requester holds the token, that is, is in load (code 2) or store (code 5), in any cycle. A holder keeps the token until its transfer-done pulse.
- R4: If the token is free, or its holder pulses transfer-done, and at least one requester is waiting (code 1 or 4), a waiting requester holds the token after the next edge. No idle cycle comes between two holders.
- R5: The next holder is the first waiting requester found when searching upward from the index after the last holder, wrapping around. Load waiters and store waiters are treated alike. After reset the search starts at index 0.
- R6: A requester in load that pulses transfer-done moves to compute (code 3). Several requesters may be in compute at once, and in compute while another requester holds the token.
- R7: A requester in compute that pulses compute-done moves to wait-store (code 4).
- R8: A requester in store that pulses transfer-done moves to wait-load if its start line is high in that cycle, and otherwise to idle.
- R9: A done pulse in any phase other than the one named in R6 to R8 has no effect, and the start line has no effect outside idle and store.
- R10: grant[i] is high exactly when requester i is in load or store. Phase field i sits at phase_o bits [3i+2:3i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | NREQ | Per requester: begin a new round (seen in idle or store) |
| compute_done_i | input | NREQ | Per requester: pulse marking the end of private compute |
| xfer_done_i | input | NREQ | Per requester: pulse marking the end of the current load or store |
| grant_o | output | NREQ | Per requester: holds the shared-memory token |
| phase_o | output | 3*NREQ | Per requester: phase code (0 idle, 1 wait-load, 2 load, 3 compute, 4 wait-store, 5 store) |

## Verification
The embedded properties check on every cycle that the token is never held twice, that a holder keeps it until its transfer-done pulse, and that a waiting requester is served without a gap whenever the token is free or being handed over. They also check that the round-robin picker's choice is one-hot and goes only to a waiting requester. The order in which requesters win, the wrap of the search pointer, the choice between wait-load and idle after a store, and the fact that stray pulses are ignored can be shown only by the bench's scenarios. The bench compares these against a scoreboard of expected winners and expected phase vectors.

// File: rtl/sparb_pkg.sv
package sparb_pkg;
  localparam int PHASE_W = 3;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE       = 3'd0,
    PH_WAIT_LOAD  = 3'd1,
    PH_LOAD       = 3'd2,
    PH_COMPUTE    = 3'd3,
    PH_WAIT_STORE = 3'd4,
    PH_STORE      = 3'd5
  } phase_e;
endpackage

// File: rtl/sparb_slot.sv
module sparb_slot
  import sparb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   compute_done_i,
  input  logic   xfer_done_i,
  input  logic   win_i,
  output phase_e phase_o,
  output logic   holding_o,
  output logic   waiting_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:       if (start_i)        ph_d = PH_WAIT_LOAD;
      PH_WAIT_LOAD:  if (win_i)          ph_d = PH_LOAD;
      PH_LOAD:       if (xfer_done_i)    ph_d = PH_COMPUTE;
      PH_COMPUTE:    if (compute_done_i) ph_d = PH_WAIT_STORE;
      PH_WAIT_STORE: if (win_i)          ph_d = PH_STORE;
      PH_STORE:      if (xfer_done_i)    ph_d = start_i ? PH_WAIT_LOAD : PH_IDLE;
      default:                           ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase_o   = ph_q;
  assign holding_o = (ph_q == PH_LOAD) || (ph_q == PH_STORE);
  assign waiting_o = (ph_q == PH_WAIT_LOAD) || (ph_q == PH_WAIT_STORE);

  // R5
  win_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_i |-> waiting_o);

  // R3
  hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (holding_o && !xfer_done_i) |=> (holding_o && $stable(phase_o)));

  // R7
  compute_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_COMPUTE && compute_done_i) |=> (phase_o == PH_WAIT_STORE));
endmodule

// File: rtl/sparb_rr.sv
module sparb_rr #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable_i,
  input  logic [NREQ-1:0] cand_i,
  output logic [NREQ-1:0] win_o
);
  localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] pick_idx;
  logic             found;

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int k = 1; k <= NREQ; k++) begin
      int idx;
      idx = int'(last_q) + k;
      if (idx >= NREQ) idx = idx - NREQ;
      if (!found && cand_i[idx]) begin
        found    = 1'b1;
        pick_idx = IDX_W'(idx);
      end
    end
  end

  always_comb begin
    win_o = '0;
    if (enable_i && found) win_o[pick_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 last_q <= IDX_W'(NREQ - 1);
    else if (enable_i && found) last_q <= pick_idx;
  end

  // R3
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_o));

  // R5
  winner_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o & ~cand_i) == '0);
endmodule

// File: rtl/sparb_top.sv
module sparb_top
  import sparb_pkg::*;
#(
  parameter int NREQ = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREQ-1:0]         start_i,
  input  logic [NREQ-1:0]         compute_done_i,
  input  logic [NREQ-1:0]         xfer_done_i,
  output logic [NREQ-1:0]         grant_o,
  output logic [PHASE_W*NREQ-1:0] phase_o
);
  logic [NREQ-1:0] holding;
  logic [NREQ-1:0] waiting;
  logic [NREQ-1:0] win;
  logic            token_free;

  // token can move this cycle if nobody holds it or the holder is finishing
  assign token_free = ~|holding || |(holding & xfer_done_i);

  sparb_rr #(.NREQ(NREQ)) u_rr (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (token_free),
    .cand_i   (waiting),
    .win_o    (win)
  );

  for (genvar i = 0; i < NREQ; i++) begin : g_slot
    phase_e ph;
    sparb_slot u_slot (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i[i]),
      .compute_done_i (compute_done_i[i]),
      .xfer_done_i    (xfer_done_i[i]),
      .win_i          (win[i]),
      .phase_o        (ph),
      .holding_o      (holding[i]),
      .waiting_o      (waiting[i])
    );
    assign phase_o[PHASE_W*i +: PHASE_W] = ph;
  end

  assign grant_o = holding;

  // R3
  single_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(holding));

  // R4
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (token_free && |waiting) |=> |holding);
endmodule

// File: tb/sparb_top_bench.sv
module sparb_top_bench;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   start_i = '0;
  logic [N-1:0]   compute_done_i = '0;
  logic [N-1:0]   xfer_done_i = '0;
  logic [N-1:0]   grant_o;
  logic [3*N-1:0] phase_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  logic [N-1:0] prev_grant = '0;
  logic mon_on = 1'b0;

  always #2 clk = ~clk;

  sparb_top #(.NREQ(N)) u_sparb_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .compute_done_i(compute_done_i), .xfer_done_i(xfer_done_i),
    .grant_o(grant_o), .phase_o(phase_o)
  );

  function automatic logic [3*N-1:0] pv(input int p0, p1, p2, p3);
    return {3'(p3), 3'(p2), 3'(p1), 3'(p0)};
  endfunction

  function automatic logic [N-1:0] gexp(input logic [3*N-1:0] p);
    logic [N-1:0] g;
    for (int i = 0; i < N; i++) g[i] = (p[3*i +: 3] == 3'd2) || (p[3*i +: 3] == 3'd5);
    return g;
  endfunction

  task automatic check(input string req, input logic [3*N-1:0] ep);
    n_chk++;
    if (phase_o !== ep || grant_o !== gexp(ep)) begin
      n_fail++;
      $display("FAIL %s phase=%h grant=%b expected phase=%h grant=%b",
               req, phase_o, grant_o, ep, gexp(ep));
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    start_i = '0; compute_done_i = '0; xfer_done_i = '0;
  endtask

  task automatic expect_win(input int idx);
    exp_q.push_back(idx);
  endtask

  // monitor: each new holder is popped from the scoreboard
  always @(posedge clk) begin
    #2;
    if (mon_on && grant_o != '0 && grant_o != prev_grant) begin
      int got;
      got = -1;
      for (int i = 0; i < N; i++) if (grant_o[i]) got = i;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5 winner=%0d expected none", got);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (got != e) begin
          n_fail++;
          $display("FAIL R5 winner=%0d expected %0d", got, e);
        end
      end
    end
    prev_grant = grant_o;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    expect_win(0); expect_win(1); expect_win(2); expect_win(3);
    expect_win(0); expect_win(1); expect_win(0); expect_win(2);
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    check("R1 reset", pv(0,0,0,0));
    mon_on = 1'b1;
    start_i = 4'hF;
    step(); check("R2 start", pv(1,1,1,1));
    step(); check("R4 first grant R5 from 0", pv(2,1,1,1));
    // R9: stray pulses on waiting requesters
    xfer_done_i = 4'b0101; compute_done_i = 4'b1000;
    step(); check("R6 R4 R9 handoff", pv(3,2,1,1));
    xfer_done_i[1] = 1'b1; compute_done_i[0] = 1'b1;
    step(); check("R7 R4", pv(4,3,2,1));
    xfer_done_i[2] = 1'b1;
    step(); check("R5 wait-load before wrap", pv(4,3,3,2));
    xfer_done_i[3] = 1'b1; compute_done_i[1] = 1'b1;
    step(); check("R6 R5 store grant", pv(5,4,3,3));
    start_i[3] = 1'b1; compute_done_i[0] = 1'b1; xfer_done_i[2] = 1'b1;
    step(); check("R3 R9 holder kept", pv(5,4,3,3));
    xfer_done_i[0] = 1'b1; start_i[0] = 1'b1;
    step(); check("R8 store to wait-load", pv(1,5,3,3));
    xfer_done_i[1] = 1'b1;
    step(); check("R8 store to idle", pv(2,0,3,3));
    xfer_done_i[0] = 1'b1;
    step(); check("R10 token idle", pv(3,0,3,3));
    compute_done_i[2] = 1'b1;
    step(); check("R7 to wait-store", pv(3,0,4,3));
    step(); check("R4 free token served", pv(3,0,5,3));
    #3;
    mon_on = 1'b0;
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R5 pending=%0d expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule